// File: doc/BRIEF.md
# Erase-Block Protection State Controller

This block keeps the volatile protection level of every erase block in a two-bank flash array. Each block is unlocked, locked or locked-down. A command decoder upstream hands it one request at a time, made of an operation code and a block index. A hardware write-protect input decides whether the locked-down level is frozen or can be released.

Two decisions are made from this state. A query port names one block and gets back, in the same cycle, whether program or erase may touch it and a two-bit lock status for auto-select reads. An erase port takes either a single-block erase or a whole-bank erase. One cycle later it returns a go or abort verdict, together with a mask of the blocks that will actually be erased. A single-block erase on a protected block aborts. A bank erase leaves out protected blocks and aborts only when the whole bank is protected.

Top module: `blk_lock_ctl`

## Requirements
- R1: While reset is asserted and right after it is released, every block reports status 2'b01 (locked, not locked-down) and program is not allowed.
- R2: A request with `req_op` 2'b01 locks the indexed block, and 2'b10 unlocks it. 2'b00 does nothing. The new state is visible on the query port from the cycle after the request edge.
- R3: `qry_status` is {locked-down bit, locked bit}, with bit 0 set for any protected block. `qry_pgm_ok` is high only for an in-range, unlocked block. An index of `NUM_BLOCKS` or more reads status 2'b00 with `qry_pgm_ok` low.
- R4: A request with `req_op` 2'b11 moves the indexed block to locked-down (status 2'b11) from any state, including unlocked.
- R5: While `wp_n` is low, lock and unlock requests on a locked-down block are ignored, and no locked-down block leaves that state.
- R6: While `wp_n` is high, an unlock request on a locked-down block makes it unlocked, and a lock request makes it plain locked.
- R7: A request whose index is `NUM_BLOCKS` or more changes no block.
- R8: A block erase (`er_bank`=0) gives `er_vld` high one cycle after the request. The verdict is `er_go` with a one-hot `er_mask` if the block was unlocked. It is `er_abort` with an empty mask if the block was locked or locked-down. With no request, `er_vld`, `er_go` and `er_abort` are low and the mask is empty.
- R9: A bank erase (`er_bank`=1) gives a mask holding exactly the unlocked blocks of the addressed bank. The verdict is `er_go` if that mask is non-empty and `er_abort` otherwise.
- R10: An erase decision uses the protection state from before any lock request made in the same cycle.
- R11: Block indices below `BANK_A_BLOCKS` (default 15) belong to the first bank. All others up to `NUM_BLOCKS`-1 (default 70) belong to the second bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; every block returns to locked |
| wp_n | input | 1 | Write-protect; low freezes locked-down blocks |
| req_valid | input | 1 | A protection request is present this cycle |
| req_op | input | 2 | 01 lock, 10 unlock, 11 lock-down, 00 none |
| req_blk | input | IW | Block index of the request |
| qry_blk | input | IW | Block index being queried |
| qry_pgm_ok | output | 1 | Queried block may be programmed or erased |
| qry_status | output | 2 | {locked-down, locked} of the queried block |
| er_req | input | 1 | Erase decision request |
| er_bank | input | 1 | 0 block erase, 1 bank erase |
| er_blk | input | IW | Target block, or any block in the target bank |
| er_vld | output | 1 | Erase verdict valid |
| er_go | output | 1 | Erase proceeds |
| er_abort | output | 1 | Erase aborts |
| er_mask | output | NUM_BLOCKS | Blocks that the erase will touch |

## Verification
The query port is combinational from the stored state. A request therefore shows up on it after exactly one rising edge, and the bench drives each request on a falling edge and reads the query at the next falling edge. Erase verdicts are registered: they appear after the edge that captures `er_req` and last one cycle. The bench reads them at the falling edge that follows, then checks at a later falling edge that the outputs have returned to idle. Same-cycle ordering is tested by putting a lock request and an erase request on the same edge.

// File: rtl/blk_lock_ctl.sv
module blk_lock_ctl #(
  parameter int NUM_BLOCKS    = 71,
  parameter int BANK_A_BLOCKS = 15,
  localparam int IW = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wp_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_op,
  input  logic [IW-1:0]         req_blk,
  input  logic [IW-1:0]         qry_blk,
  output logic                  qry_pgm_ok,
  output logic [1:0]            qry_status,
  input  logic                  er_req,
  input  logic                  er_bank,
  input  logic [IW-1:0]         er_blk,
  output logic                  er_vld,
  output logic                  er_go,
  output logic                  er_abort,
  output logic [NUM_BLOCKS-1:0] er_mask
);

  localparam logic [1:0] OP_LOCK = 2'b01;
  localparam logic [1:0] OP_UNLK = 2'b10;
  localparam logic [1:0] OP_DOWN = 2'b11;
  localparam logic [NUM_BLOCKS-1:0] SEL_B = {NUM_BLOCKS{1'b1}} << BANK_A_BLOCKS;
  localparam logic [NUM_BLOCKS-1:0] ONE   = NUM_BLOCKS'(1);

  logic [NUM_BLOCKS-1:0] lk;
  logic [NUM_BLOCKS-1:0] ld;

  logic req_in, qry_in, er_in, frozen, er_in_b;
  logic [NUM_BLOCKS-1:0] cand;

  assign req_in  = int'(req_blk) < NUM_BLOCKS;
  assign qry_in  = int'(qry_blk) < NUM_BLOCKS;
  assign er_in   = int'(er_blk)  < NUM_BLOCKS;
  assign frozen  = req_in && ld[req_blk] && !wp_n;
  assign er_in_b = int'(er_blk) >= BANK_A_BLOCKS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk <= '1;
      ld <= '0;
    end else if (req_valid && req_in && !frozen) begin
      case (req_op)
        OP_LOCK: begin lk[req_blk] <= 1'b1; ld[req_blk] <= 1'b0; end
        OP_UNLK: begin lk[req_blk] <= 1'b0; ld[req_blk] <= 1'b0; end
        OP_DOWN: begin lk[req_blk] <= 1'b1; ld[req_blk] <= 1'b1; end
        default: ;
      endcase
    end
  end

  assign qry_status = qry_in ? {ld[qry_blk], lk[qry_blk]} : 2'b00;
  assign qry_pgm_ok = qry_in && !lk[qry_blk];

  always_comb begin
    cand = '0;
    if (er_in) begin
      if (er_bank)
        cand = ~lk & (er_in_b ? SEL_B : ~SEL_B);
      else if (!lk[er_blk])
        cand = ONE << er_blk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      er_vld   <= 1'b0;
      er_go    <= 1'b0;
      er_abort <= 1'b0;
      er_mask  <= '0;
    end else begin
      er_vld   <= er_req;
      er_go    <= er_req && (|cand);
      er_abort <= er_req && !(|cand);
      er_mask  <= er_req ? cand : '0;
    end
  end

  p_pgm_unlocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qry_pgm_ok |-> (qry_status == 2'b00));

  p_down_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> ((ld & $past(ld)) == $past(ld)));

  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    er_vld |-> (er_go != er_abort));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !er_vld |-> (!er_go && !er_abort && er_mask == '0));

  p_block_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (er_req && !er_bank) |=> (er_abort || $countones(er_mask) == 1));

  p_abort_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    er_abort |-> (er_mask == '0));

  p_mask_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    er_req |=> ((er_mask & $past(lk)) == '0));

endmodule

// File: tb/sim_blk_lock_ctl.sv
module sim_blk_lock_ctl;
  localparam int N = 71;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [6:0] req_blk = '0;
  logic [6:0] qry_blk = '0;
  logic qry_pgm_ok;
  logic [1:0] qry_status;
  logic er_req = 1'b0;
  logic er_bank = 1'b0;
  logic [6:0] er_blk = '0;
  logic er_vld, er_go, er_abort;
  logic [N-1:0] er_mask;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  blk_lock_ctl u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk),
    .qry_blk(qry_blk), .qry_pgm_ok(qry_pgm_ok), .qry_status(qry_status),
    .er_req(er_req), .er_bank(er_bank), .er_blk(er_blk),
    .er_vld(er_vld), .er_go(er_go), .er_abort(er_abort), .er_mask(er_mask)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // {op[1:0], blk[6:0], wp_n, exp_status[1:0], exp_ok}
  localparam int NV = 13;
  localparam logic [12:0] VEC [NV] = '{
    {2'b10, 7'd3,  1'b1, 2'b00, 1'b1},  // R2 unlock
    {2'b01, 7'd3,  1'b1, 2'b01, 1'b0},  // R2 lock
    {2'b11, 7'd3,  1'b0, 2'b11, 1'b0},  // R4 lock-down from locked
    {2'b10, 7'd3,  1'b0, 2'b11, 1'b0},  // R5 unlock ignored
    {2'b01, 7'd3,  1'b0, 2'b11, 1'b0},  // R5 lock ignored
    {2'b10, 7'd3,  1'b1, 2'b00, 1'b1},  // R6 release by unlock
    {2'b11, 7'd3,  1'b1, 2'b11, 1'b0},  // R4 lock-down from unlocked
    {2'b01, 7'd3,  1'b1, 2'b01, 1'b0},  // R6 lock drops lock-down
    {2'b10, 7'd70, 1'b0, 2'b00, 1'b1},  // R2 last block
    {2'b11, 7'd70, 1'b0, 2'b11, 1'b0},  // R4
    {2'b10, 7'd70, 1'b1, 2'b00, 1'b1},  // R6
    {2'b00, 7'd70, 1'b1, 2'b00, 1'b1},  // R2 no-op code
    {2'b10, 7'd71, 1'b1, 2'b00, 1'b0}   // R7 and R3 out of range
  };

  task automatic rq(input logic [1:0] op, input logic [6:0] b, input logic wp);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_blk = b; wp_n = wp; qry_blk = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic er(input logic bank, input logic [6:0] b);
    @(negedge clk);
    er_req = 1'b1; er_bank = bank; er_blk = b;
    @(negedge clk);
    er_req = 1'b0;
  endtask

  task automatic chk_er(input string tag, input logic go, input logic [N-1:0] m);
    chk({tag, " vld"}, 128'(er_vld), 128'(1'b1));
    chk({tag, " go"}, 128'(er_go), 128'(go));
    chk({tag, " abort"}, 128'(er_abort), 128'(!go));
    chk({tag, " mask"}, 128'(er_mask), 128'(m));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] m;
    repeat (3) @(negedge clk);
    qry_blk = 7'd9;
    #1 chk("R1 in reset", 128'(qry_status), 128'(2'b01));
    rst_n = 1'b1;
    for (int b = 0; b < N; b++) begin
      qry_blk = 7'(b);
      #1 chk("R1 after reset", 128'({qry_status, qry_pgm_ok}), 128'(3'b010));
    end

    for (int i = 0; i < NV; i++) begin
      rq(VEC[i][12:11], VEC[i][10:4], VEC[i][3]);
      chk($sformatf("table row %0d", i), 128'({qry_status, qry_pgm_ok}), 128'(VEC[i][2:0]));
    end
    qry_blk = 7'd0;
    #1 chk("R7 neighbour untouched", 128'({qry_status, qry_pgm_ok}), 128'(3'b010));
    qry_blk = 7'd100;
    #1 chk("R3 out of range query", 128'({qry_status, qry_pgm_ok}), 128'(3'b000));
    #1 chk("R8 idle", 128'({er_vld, er_go, er_abort}), 128'(3'b000));

    er(1'b0, 7'd3);
    chk_er("R8 block locked", 1'b0, '0);
    m = '0; m[70] = 1'b1;
    er(1'b0, 7'd70);
    chk_er("R8 block unlocked", 1'b1, m);
    er(1'b1, 7'd0);
    chk_er("R9 bank all protected", 1'b0, '0);

    rq(2'b10, 7'd5, 1'b1);
    rq(2'b10, 7'd14, 1'b1);
    m = '0; m[5] = 1'b1; m[14] = 1'b1;
    er(1'b1, 7'd2);
    chk_er("R9 first bank skips", 1'b1, m);
    m = '0; m[70] = 1'b1;
    er(1'b1, 7'd20);
    chk_er("R9 second bank", 1'b1, m);
    rq(2'b10, 7'd15, 1'b1);
    m = '0; m[15] = 1'b1; m[70] = 1'b1;
    er(1'b1, 7'd15);
    chk_er("R11 boundary block", 1'b1, m);

    rq(2'b11, 7'd70, 1'b0);
    er(1'b0, 7'd70);
    chk_er("R8 block locked-down", 1'b0, '0);

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; req_blk = 7'd15;
    er_req = 1'b1; er_bank = 1'b0; er_blk = 7'd15; qry_blk = 7'd15;
    @(negedge clk);
    req_valid = 1'b0; er_req = 1'b0;
    m = '0; m[15] = 1'b1;
    chk_er("R10 same-cycle lock", 1'b1, m);
    chk("R10 lock applied", 128'(qry_status), 128'(2'b01));
    @(negedge clk);
    chk("R8 back to idle", 128'({er_vld, er_go, er_abort, |er_mask}), 128'(4'b0000));

    summary();
    $finish;
  end
endmodule